// File: doc/BRIEF.md
# Compare-Match Triggered Pulse Pattern Generator

This block drives a multi-phase pulse pattern, such as a stepper-motor phase sequence, onto a set of output bits. Several free-running period timers each raise a compare-match event once per programmed cycle. The host, or an automatic feeder, writes the following pattern into a next-data register at any point during the cycle. The loaded output register changes only when a selected compare match occurs.

The outputs are split into 4-bit groups. Each group has its own trigger-select field, which picks the timer whose match reloads that group, so the groups can step on different timers. Each output bit has an enable. A disabled bit stays at 0 whatever the pattern holds.

Each timer has a sticky event flag, which is cleared by writing one to it. With its enable set, the flag gives a level interrupt. The same enable gives a one-cycle request strobe on each match, and a feeder can use that strobe to supply successive patterns without the host taking part. All configuration goes through a single register-write port.

Top module: `pulse_pattern_gen`

## Requirements
- R1: While timer k runs, its counter steps by one each cycle and clears to zero in the cycle after it equals period k. A match therefore repeats every period+1 cycles. The first match comes period+1 cycles after the run bit is written.
- R2: With a period of 0 and the timer running, timer k matches in every cycle and its counter stays at zero.
- R3: When the timer selected for a group matches, the whole 4-bit group of the output register is loaded from the same group of next-data (address 0). The new value shows on `pulse_o` in the next cycle.
- R4: Output bit i drives the output register bit only when bit i of the enable register (address 1) is 1. Otherwise the output bit is 0.
- R5: Bits [2g+1:2g] of the trigger-select register (address 2) choose which timer reloads group g (output bits [4g+3:4g]). Each group updates on its own timer, independently of the other groups.
- R6: A write to next-data between matches leaves `pulse_o` unchanged until the next selected match.
- R7: When a next-data write and a selected match fall on the same clock edge, the output register takes the old next-data value. The written value stays buffered for the following match.
- R8: Each match sets event flag k, and the flag stays set. Writing 1 to bit k of the status register (address 4) clears it, but a match in the same cycle wins. `irq_o[k]` is the level flag[k] AND enable bit k of the interrupt-enable register (address 3).
- R9: `req_o[k]` is high for exactly one cycle, the cycle in which the output register shows a load triggered by timer k, provided interrupt-enable bit k was 1 at the match. A feeder answering this strobe keeps the ten-step five-phase pattern 0x80, 0xC0, 0x40, 0x60, 0x20, 0x30, 0x10, 0x18, 0x08, 0x88 stepping, with one or two bits high in every step.
- R10: After reset, all counters, next-data, the output register, the enables, the flags and the periods are zero. Every output is low.
- R11: Bit k of the run register (address 5) starts timer k. A stopped timer holds its count and produces no match. Period k is written at address 8+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pulse_o | output | WIDTH | Masked pattern outputs |
| irq_o | output | 2**SEL_W | Per-timer interrupt level |
| req_o | output | 2**SEL_W | Per-timer one-cycle feeder request |

## Verification
The bench goes after the write that lands on the same edge as a match. A design that forwarded the written data would show the new pattern one match early and then skip a step. It also drives a zero period, where a counter that did not hold at zero would wrap through its whole range and go silent. Other checks cover a status clear that meets a match, where a clear that won would drop an event the feeder needs, and groups tied to different timers, where shared loading would update both groups on the faster timer. Random register traffic is compared cycle by cycle against a bench model, which catches masking and select-decoding slips.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int GRP_W  = 4;

    localparam logic [ADDR_W-1:0] A_NEXT     = 4'h0;
    localparam logic [ADDR_W-1:0] A_OEN      = 4'h1;
    localparam logic [ADDR_W-1:0] A_TSEL     = 4'h2;
    localparam logic [ADDR_W-1:0] A_IEN      = 4'h3;
    localparam logic [ADDR_W-1:0] A_STAT     = 4'h4;
    localparam logic [ADDR_W-1:0] A_RUN      = 4'h5;
    localparam logic [ADDR_W-1:0] A_PER_BASE = 4'h8;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic hit(wr_req_t w, logic [ADDR_W-1:0] a);
        return w.en && (w.addr == a);
    endfunction
endpackage

// File: rtl/ppg_timer.sv
module ppg_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] period,
    output logic          match
);
    logic [TW-1:0] cnt;

    assign match = run && (cnt == period);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (match) cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
    end

    // R1 / R2: a match always returns the counter to zero
    assert_clear_on_match_R1: assert property (@(posedge clk) disable iff (rst)
        match |=> (cnt == '0));

    // R11: a stopped timer keeps its count
    assert_hold_stopped_R11: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt));
endmodule

// File: rtl/ppg_regs.sv
module ppg_regs import ppg_pkg::*; #(
    parameter int WIDTH = 8,
    parameter int TW    = 16,
    parameter int SEL_W = 2,
    parameter int NSRC  = 4,
    parameter int NGRP  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  wr_req_t                   wr,
    input  logic [NSRC-1:0]           match,
    output logic [WIDTH-1:0]          ndr,
    output logic [WIDTH-1:0]          oen,
    output logic [NGRP*SEL_W-1:0]     tsel,
    output logic [NSRC-1:0]           ien,
    output logic [NSRC-1:0]           run,
    output logic [NSRC-1:0]           flag,
    output logic [NSRC-1:0][TW-1:0]   per
);
    logic [NSRC-1:0] clr;

    assign clr = hit(wr, A_STAT) ? wr.data[NSRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ndr  <= '0;
            oen  <= '0;
            tsel <= '0;
            ien  <= '0;
            run  <= '0;
            flag <= '0;
        end else begin
            if (hit(wr, A_NEXT)) ndr  <= wr.data[WIDTH-1:0];
            if (hit(wr, A_OEN))  oen  <= wr.data[WIDTH-1:0];
            if (hit(wr, A_TSEL)) tsel <= wr.data[NGRP*SEL_W-1:0];
            if (hit(wr, A_IEN))  ien  <= wr.data[NSRC-1:0];
            if (hit(wr, A_RUN))  run  <= wr.data[NSRC-1:0];
            flag <= (flag & ~clr) | match;
        end
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_per
        always_ff @(posedge clk) begin
            if (rst)                                   per[k] <= '0;
            else if (hit(wr, ADDR_W'(A_PER_BASE + k))) per[k] <= wr.data[TW-1:0];
        end
    end

    // R8: every match leaves its flag set, even against a clear
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (match != '0) |=> ((flag & $past(match)) == $past(match)));
endmodule

// File: rtl/ppg_outgrp.sv
module ppg_outgrp #(
    parameter int SEL_W = 2,
    parameter int NSRC  = 4,
    parameter int GW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  match,
    input  logic [SEL_W-1:0] sel,
    input  logic [GW-1:0]    nxt,
    input  logic [GW-1:0]    oe,
    output logic [GW-1:0]    pins
);
    logic [GW-1:0] odr;
    logic          load;

    assign load = match[sel];
    assign pins = odr & oe;

    always_ff @(posedge clk) begin
        if (rst)       odr <= '0;
        else if (load) odr <= nxt;
    end

    // R3 / R7: a load takes next-data as it stood before the edge
    assert_load_old_next_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (odr == $past(nxt)));

    // R6: without a selected match the output register holds
    assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(odr));
endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen import ppg_pkg::*; #(
    parameter int WIDTH = 8,
    parameter int TW    = 16,
    parameter int SEL_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [WIDTH-1:0]        pulse_o,
    output logic [(1<<SEL_W)-1:0]   irq_o,
    output logic [(1<<SEL_W)-1:0]   req_o
);
    localparam int NSRC = 1 << SEL_W;
    localparam int NGRP = WIDTH / GRP_W;

    wr_req_t                  wr;
    logic [NSRC-1:0]          match, run, ien, flag, req_q;
    logic [NSRC-1:0][TW-1:0]  per;
    logic [WIDTH-1:0]         ndr, oen;
    logic [NGRP*SEL_W-1:0]    tsel;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    ppg_regs #(
        .WIDTH(WIDTH), .TW(TW), .SEL_W(SEL_W), .NSRC(NSRC), .NGRP(NGRP)
    ) regs_i (
        .clk(clk), .rst(rst), .wr(wr), .match(match),
        .ndr(ndr), .oen(oen), .tsel(tsel), .ien(ien),
        .run(run), .flag(flag), .per(per)
    );

    for (genvar k = 0; k < NSRC; k++) begin : g_tmr
        ppg_timer #(.TW(TW)) tmr_i (
            .clk(clk), .rst(rst), .run(run[k]),
            .period(per[k]), .match(match[k])
        );
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        ppg_outgrp #(.SEL_W(SEL_W), .NSRC(NSRC), .GW(GRP_W)) grp_i (
            .clk(clk), .rst(rst), .match(match),
            .sel(tsel[g*SEL_W +: SEL_W]),
            .nxt(ndr[g*GRP_W +: GRP_W]),
            .oe(oen[g*GRP_W +: GRP_W]),
            .pins(pulse_o[g*GRP_W +: GRP_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= match & ien;
    end

    assign req_o = req_q;
    assign irq_o = flag & ien;

    // R9: the strobe follows each enabled match by exactly one cycle
    assert_req_follows_match_R9: assert property (@(posedge clk) disable iff (rst)
        (|(match & ien)) |=> (req_o == $past(match & ien)));
endmodule

// File: tb/pulse_pattern_gen_tb.sv
module pulse_pattern_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int TW = 16;
    localparam int SW = 2;
    localparam int NS = 1 << SW;
    localparam int NG = W / 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [W-1:0]  pulse_o;
    logic [NS-1:0] irq_o, req_o;

    int    checks = 0;
    int    errors = 0;
    string tag = "R10";
    bit    done = 0;

    logic [TW-1:0]   m_cnt [NS];
    logic [TW-1:0]   m_per [NS];
    logic [NS-1:0]   m_run, m_ien, m_flag, m_req;
    logic [W-1:0]    m_ndr, m_odr, m_oe;
    logic [NG*SW-1:0] m_sel;

    pulse_pattern_gen #(.WIDTH(W), .TW(TW), .SEL_W(SW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pulse_o(pulse_o), .irq_o(irq_o), .req_o(req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void chk(string name, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", name, got, exp);
        end
    endfunction

    function automatic void model_reset();
        for (int k = 0; k < NS; k++) begin m_cnt[k] = '0; m_per[k] = '0; end
        m_run = '0; m_ien = '0; m_flag = '0; m_req = '0;
        m_ndr = '0; m_odr = '0; m_oe = '0; m_sel = '0;
    endfunction

    function automatic void model_step();
        logic [NS-1:0] mt;
        logic [NS-1:0] clr;
        for (int k = 0; k < NS; k++) mt[k] = m_run[k] && (m_cnt[k] == m_per[k]);
        for (int g = 0; g < NG; g++)
            if (mt[m_sel[g*SW +: SW]]) m_odr[g*4 +: 4] = m_ndr[g*4 +: 4];
        m_req = mt & m_ien;
        clr = (wr_en && wr_addr == 4'h4) ? wr_data[NS-1:0] : '0;
        m_flag = (m_flag & ~clr) | mt;
        for (int k = 0; k < NS; k++)
            if (mt[k]) m_cnt[k] = '0;
            else if (m_run[k]) m_cnt[k] = m_cnt[k] + 1'b1;
        if (wr_en) begin
            case (wr_addr)
                4'h0: m_ndr = wr_data[W-1:0];
                4'h1: m_oe  = wr_data[W-1:0];
                4'h2: m_sel = wr_data[NG*SW-1:0];
                4'h3: m_ien = wr_data[NS-1:0];
                4'h5: m_run = wr_data[NS-1:0];
                default: if (wr_addr >= 4'h8 && wr_addr < 4'h8 + NS)
                    m_per[wr_addr - 4'h8] = wr_data[TW-1:0];
            endcase
        end
    endfunction

    task automatic tick();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        #1;
        chk({tag, " pulse"}, 16'(pulse_o), 16'(m_odr & m_oe));
        chk({tag, " irq"},   16'(irq_o),   16'(m_flag & m_ien));
        chk({tag, " req"},   16'(req_o),   16'(m_req));
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
    endtask

    logic [7:0] seq [10];

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        seq = '{8'h80, 8'hC0, 8'h40, 8'h60, 8'h20, 8'h30, 8'h10, 8'h18, 8'h08, 8'h88};
        void'($urandom(32'd1234));

        // R10: reset state
        tag = "R10";
        do_reset();
        chk("R10 pulse after reset", 16'(pulse_o), 16'h0);
        chk("R10 irq after reset", 16'(irq_o), 16'h0);

        // R1 / R11: first match period+1 cycles after start
        tag = "R1";
        wr(4'h1, 16'h00FF);
        wr(4'h0, 16'h005A);
        wr(4'h8, 16'd2);
        wr(4'h5, 16'h0001);
        tick(); chk("R1 no load yet", 16'(pulse_o), 16'h0);
        tick(); chk("R1 no load yet", 16'(pulse_o), 16'h0);
        tick(); chk("R1 first load", 16'(pulse_o), 16'h5A);

        // R6: next-data write between matches does not reach outputs
        tag = "R6";
        wr(4'h0, 16'h0033);
        chk("R6 held", 16'(pulse_o), 16'h5A);
        tick(); chk("R6 held", 16'(pulse_o), 16'h5A);
        tick(); chk("R6 loaded at match", 16'(pulse_o), 16'h33);

        // R11: stopped timer gives no match
        tag = "R11";
        wr(4'h5, 16'h0000);
        wr(4'h0, 16'h00EE);
        for (int i = 0; i < 8; i++) tick();
        chk("R11 no load while stopped", 16'(pulse_o), 16'h33);

        // R2 / R7 / R8: period zero, collision, sticky flag
        tag = "R2";
        do_reset();
        wr(4'h1, 16'h00FF);
        wr(4'h3, 16'h0001);
        wr(4'h5, 16'h0001);
        tick(); chk("R2 match every cycle req", 16'(req_o), 16'h1);
        tick(); chk("R2 match every cycle req", 16'(req_o), 16'h1);
        tag = "R7";
        wr(4'h0, 16'h0011);
        chk("R7 old next-data on collision", 16'(pulse_o), 16'h00);
        tick(); chk("R7 buffered value loaded", 16'(pulse_o), 16'h11);
        tag = "R8";
        wr(4'h4, 16'h0001);
        chk("R8 match beats clear", 16'(irq_o), 16'h1);
        wr(4'h5, 16'h0000);
        tick(); chk("R8 flag sticky", 16'(irq_o), 16'h1);
        wr(4'h4, 16'h0001);
        chk("R8 cleared by write-one", 16'(irq_o), 16'h0);

        // R5: groups on different timers
        tag = "R5";
        do_reset();
        wr(4'h1, 16'h00FF);
        wr(4'h0, 16'h00AB);
        wr(4'h8, 16'd1);
        wr(4'h9, 16'd4);
        wr(4'h2, 16'b0100);
        wr(4'h5, 16'h0003);
        tick(); tick(); chk("R5 low group only", 16'(pulse_o), 16'h0B);
        tick(); tick(); tick(); chk("R5 high group later", 16'(pulse_o), 16'hAB);

        // R4: per-bit enables
        tag = "R4";
        wr(4'h1, 16'h0069);
        chk("R4 masked bits zero", 16'(pulse_o), 16'h29);

        // R9: five-phase pattern fed from request strobe
        tag = "R9";
        do_reset();
        wr(4'h1, 16'h00F8);
        wr(4'h3, 16'h0001);
        wr(4'h8, 16'd3);
        wr(4'h0, 16'h0080);
        wr(4'h5, 16'h0001);
        begin
            int idx = 0;
            int seen = 0;
            for (int i = 0; i < 400 && seen < 20; i++) begin
                tick();
                if (req_o[0]) begin
                    chk("R9 pattern step", 16'(pulse_o), 16'(seq[seen % 10]));
                    checks++;
                    if ($countones(pulse_o) < 1 || $countones(pulse_o) > 2) begin
                        errors++;
                        $display("FAIL R9 phase count got %0d expected 1..2", $countones(pulse_o));
                    end
                    seen++;
                    idx = (idx + 1) % 10;
                    wr(4'h0, 16'(seq[idx]));
                end
            end
            chk("R9 steps seen", 16'(seen), 16'd20);
        end

        // R3 / R4 / R5 / R8: random register traffic against the model
        tag = "R3";
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) < 3) begin
                logic [3:0] a;
                logic [15:0] d;
                a = 4'($urandom_range(0, 9));
                if (a > 4'h5) a = a + 4'h2;
                d = 16'($urandom);
                if (a >= 4'h8) d = d & 16'h0007;
                if (a == 4'h5) d = d | 16'h0001;
                wr_en = 1'b1; wr_addr = a; wr_data = d;
            end
            tick();
            wr_en = 1'b0;
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule